// File: doc/BRIEF.md
# User Scratch Memory Wipe Controller

This block erases a small user scratch memory in response to an external, active-low wipe request pin. The pin passes through a flop synchronizer and a falling-edge detector. When software has armed the wipe, a detected edge starts a sequencer that writes all-ones to every byte of the scratch array, one byte per clock, through a dedicated write port. The block touches only the scratch array. It has no access to the timekeeping registers or to any other storage.

When the last byte has been written, a sticky completion flag is set. If the interrupt enable is set, an active-low interrupt output is driven. A single pending-interrupt input from the rest of the chip is merged into the same output. Software clears the flag by writing zero to its bit. From the accepted edge onward, a bus lockout output stays high until the fill has finished and a recovery count has also run out.

Top module: `uwipe`

## Requirements
- R1: A wipe starts only on a falling edge of `clr_n`, seen after a two-flop synchronizer, while the enable bit (`ctl_rdata[0]`) is 1. The first write reaches the write port a few cycles after the pin falls.
- R2: A wipe writes every address from 0 to DEPTH-1 (114 by default) exactly once, in ascending order, on consecutive cycles. The data is all ones (8'hFF).
- R3: While the enable bit is 0, edges on `clr_n` produce no write, no lockout and no change to the completion flag.
- R4: The completion flag (`ctl_rdata[2]`) is set on the clock edge that retires the last write, and it stays set.
- R5: `irq_n` is low one cycle after (flag AND interrupt enable `ctl_rdata[1]`) OR `ext_irq` is true. Otherwise it is high.
- R6: A control write (`ctl_we`) loads enable from `ctl_wdata[0]` and interrupt enable from `ctl_wdata[1]`. It clears the flag when `ctl_wdata[2]` is 0. Writing 1 to `ctl_wdata[2]` leaves the flag unchanged.
- R7: `bus_lock` rises together with the first write and stays high for max(REC_CYCLES, DEPTH) cycles.
- R8: A falling edge on `clr_n` that is detected while a fill is running is ignored. The fill still writes exactly DEPTH bytes.
- R9: If a flag-clearing control write and the completion of a fill fall on the same edge, the flag ends up set.
- R10: After reset, `irq_n` is 1, `bus_lock` is 0, `wr_en` is 0 and `ctl_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Asynchronous active-low wipe request pin |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control write data: bit0 enable, bit1 interrupt enable, bit2 flag (0 clears) |
| ctl_rdata | output | 3 | Control state: bit0 enable, bit1 interrupt enable, bit2 completion flag |
| ext_irq | input | 1 | Other pending interrupt sources, active high |
| irq_n | output | 1 | Active-low interrupt |
| bus_lock | output | 1 | Bus access lockout |
| wr_en | output | 1 | Scratch array write enable |
| wr_addr | output | ADDR_W (7) | Scratch array write address |
| wr_data | output | DATA_W (8) | Scratch array write data |

## Verification
The completion of a fill, which sets the flag, and a software write of zero to the flag can land on the same clock edge. The bench provokes this by watching the write port until the last address is presented. It then drives the flag-clearing control write during that same cycle, so that both take effect at one edge. The flag must read back as set afterwards, and the interrupt must then follow it low. A later separate clear must release the interrupt.

// File: rtl/uwipe_pkg.sv
package uwipe_pkg;

  typedef struct packed {
    logic flag;
    logic ie;
    logic en;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/uwipe_sync.sv
module uwipe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic fall
);

  logic [STAGES-1:0] sh;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sh[0] <= 1'b1;
          else     sh[0] <= pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sh[i] <= 1'b1;
          else     sh[i] <= sh[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= sh[STAGES-1];
  end

  assign fall = prev & ~sh[STAGES-1];

endmodule

// File: rtl/uwipe_seq.sv
module uwipe_seq #(
  parameter int DEPTH  = 114,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  output logic              accept,
  output logic              busy_nxt,
  output logic              fill_last,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  assign accept    = start_req & ~wr_en;
  assign fill_last = wr_en & (wr_addr == LAST_ADDR);
  assign busy_nxt  = accept | (wr_en & ~fill_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (accept) begin
      wr_en   <= 1'b1;
      wr_addr <= '0;
      wr_data <= '1;
    end else if (wr_en) begin
      if (fill_last) begin
        wr_en   <= 1'b0;
        wr_addr <= '0;
        wr_data <= '0;
      end else begin
        wr_addr <= wr_addr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/uwipe_lock.sv
module uwipe_lock #(
  parameter int REC_CYCLES = 160,
  localparam int CNT_W = $clog2(REC_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic busy_nxt,
  output logic bus_lock
);

  logic [CNT_W-1:0] cnt, cnt_nxt;

  always_comb begin
    if (start)           cnt_nxt = CNT_W'(REC_CYCLES);
    else if (cnt != '0)  cnt_nxt = cnt - 1'b1;
    else                 cnt_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      bus_lock <= 1'b0;
    end else begin
      cnt      <= cnt_nxt;
      bus_lock <= (cnt_nxt != '0) | busy_nxt;
    end
  end

endmodule

// File: rtl/uwipe_regs.sv
module uwipe_regs
  import uwipe_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             fill_done,
  input  logic             ext_irq,
  output logic [CTL_W-1:0] ctl_rdata,
  output logic             armed,
  output logic             irq_n
);

  ctl_t q, w;

  assign w = ctl_t'(ctl_wdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      if (ctl_we) begin
        q.en <= w.en;
        q.ie <= w.ie;
      end
      if (fill_done)               q.flag <= 1'b1;
      else if (ctl_we && !w.flag)  q.flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~((q.flag & q.ie) | ext_irq);
  end

  assign ctl_rdata = q;
  assign armed     = q.en;

endmodule

// File: rtl/uwipe.sv
module uwipe
  import uwipe_pkg::*;
#(
  parameter int DEPTH       = 114,
  parameter int DATA_W      = 8,
  parameter int REC_CYCLES  = 160,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_n,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  input  logic              ext_irq,
  output logic              irq_n,
  output logic              bus_lock,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  logic fall, armed, accept, busy_nxt, fill_last;

  uwipe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin_n (clr_n),
    .fall  (fall)
  );

  uwipe_seq #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_req (fall & armed),
    .accept    (accept),
    .busy_nxt  (busy_nxt),
    .fill_last (fill_last),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  uwipe_lock #(.REC_CYCLES(REC_CYCLES)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .busy_nxt (busy_nxt),
    .bus_lock (bus_lock)
  );

  uwipe_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .fill_done (fill_last),
    .ext_irq   (ext_irq),
    .ctl_rdata (ctl_rdata),
    .armed     (armed),
    .irq_n     (irq_n)
  );

endmodule

// File: rtl/uwipe_chk.sv
module uwipe_chk #(
  parameter int DEPTH  = 114,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        ctl_rdata,
  input logic              ext_irq,
  input logic              irq_n,
  input logic              bus_lock,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);

  // R1: a fill only begins if the enable bit was set
  a_r1_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_en) |-> $past(ctl_rdata[0]));

  // R2: data is all ones and address in range during a fill
  a_r2_data_all_ones: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_data == {DATA_W{1'b1}}) && (int'(wr_addr) < DEPTH));

  // R2: consecutive writes step the address by one
  a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> wr_addr == $past(wr_addr) + 1'b1);

  // R4: flag rises only right after the last write
  a_r4_flag_after_last: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_rdata[2]) |-> ($past(wr_en) && int'($past(wr_addr)) == DEPTH - 1));

  // R5: interrupt follows flag/enable/external one cycle later
  a_r5_irq_low: assert property (@(posedge clk) disable iff (rst)
    ((ctl_rdata[2] && ctl_rdata[1]) || ext_irq) |=> !irq_n);

  a_r5_irq_high: assert property (@(posedge clk) disable iff (rst)
    !((ctl_rdata[2] && ctl_rdata[1]) || ext_irq) |=> irq_n);

  // R7: the bus is locked whenever a write is in flight
  a_r7_lock_covers_fill: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> bus_lock);

endmodule

bind uwipe uwipe_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctl_rdata (ctl_rdata),
  .ext_irq   (ext_irq),
  .irq_n     (irq_n),
  .bus_lock  (bus_lock),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data)
);

// File: tb/uwipe_tb.sv
`timescale 1ns/1ps
module uwipe_tb;

  localparam int N   = 114;
  localparam int REC = 160;
  localparam int AW  = $clog2(N);
  localparam int LOCK_EXP = (REC > N) ? REC : N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clr_n = 1'b1;
  logic          ctl_we = 1'b0;
  logic [2:0]    ctl_wdata = '0;
  logic [2:0]    ctl_rdata;
  logic          ext_irq = 1'b0;
  logic          irq_n, bus_lock, wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;

  int checks = 0;
  int fails  = 0;
  int wr_count = 0, order_bad = 0, data_bad = 0, lock_cnt = 0, exp_next = 0;
  logic [7:0] mem  [N];
  logic [7:0] snap [N];
  bit exp_flag = 0;

  always #4 clk = ~clk;

  uwipe #(.DEPTH(N), .REC_CYCLES(REC)) u_dut (
    .clk(clk), .rst(rst), .clr_n(clr_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .ext_irq(ext_irq), .irq_n(irq_n), .bus_lock(bus_lock),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // scratch array model and port monitors
  always @(negedge clk) begin
    if (!rst && wr_en) begin
      if (int'(wr_addr) != exp_next) order_bad++;
      if (wr_data != 8'hFF) data_bad++;
      if (int'(wr_addr) < N) mem[wr_addr] = wr_data;
      exp_next = int'(wr_addr) + 1;
      wr_count++;
    end
    if (!rst && bus_lock) lock_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl_write(input logic [2:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
    exp_flag = exp_flag & v[2];
  endtask

  task automatic pulse(input int low);
    @(negedge clk);
    clr_n = 1'b0;
    cyc(low);
    clr_n = 1'b1;
  endtask

  task automatic prep_round();
    for (int i = 0; i < N; i++) begin
      mem[i]  = 8'($urandom_range(0, 254));
      snap[i] = mem[i];
    end
    wr_count = 0; order_bad = 0; data_bad = 0; lock_cnt = 0; exp_next = 0;
  endtask

  task automatic judge(input bit en, input bit ie, input string tag);
    int ones = 0, same = 0;
    for (int i = 0; i < N; i++) begin
      if (mem[i] == 8'hFF) ones++;
      if (mem[i] == snap[i]) same++;
    end
    if (en) begin
      exp_flag = 1'b1;
      check(wr_count == N && order_bad == 0 && data_bad == 0, {"R2 ", tag}, wr_count, N);
      check(ones == N, {"R2 all ones ", tag}, ones, N);
      check(lock_cnt == LOCK_EXP, {"R7 lock length ", tag}, lock_cnt, LOCK_EXP);
    end else begin
      check(wr_count == 0 && same == N, {"R3 no writes ", tag}, wr_count, 0);
      check(lock_cnt == 0, {"R3 no lock ", tag}, lock_cnt, 0);
    end
    check(ctl_rdata[2] == exp_flag, {"R4 flag ", tag}, ctl_rdata[2], exp_flag);
    check(irq_n == !((exp_flag & ie) | ext_irq), {"R5 irq ", tag}, irq_n,
          !((exp_flag & ie) | ext_irq));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    cyc(4);
    rst = 1'b0;
    cyc(1);
    // R10 reset state
    check(irq_n == 1'b1 && bus_lock == 1'b0 && wr_en == 1'b0, "R10 outputs", irq_n, 1);
    check(ctl_rdata == 3'b000, "R10 ctl", ctl_rdata, 0);

    // R1/R2/R4/R5/R7 basic armed wipe with interrupt enable
    ctl_write(3'b011);
    check(ctl_rdata == 3'b011, "R6 load bits", ctl_rdata, 3);
    prep_round();
    pulse(4);
    cyc(10);
    check(wr_count > 0, "R1 fill started", wr_count, 1);
    cyc(REC + 20);
    judge(1'b1, 1'b1, "basic");

    // R6 writing 1 to flag keeps it, writing 0 clears it and releases irq
    ctl_write(3'b111);
    cyc(2);
    check(ctl_rdata[2] == 1'b1, "R6 write one keeps flag", ctl_rdata[2], 1);
    ctl_write(3'b011);
    cyc(2);
    check(ctl_rdata[2] == 1'b0 && irq_n == 1'b1, "R6 flag clear", {ctl_rdata[2], irq_n}, 1);

    // R5 external source holds irq low across flag clear
    prep_round();
    pulse(3);
    cyc(REC + 20);
    ext_irq = 1'b1;
    ctl_write(3'b011);
    cyc(2);
    check(irq_n == 1'b0, "R5 ext keeps irq", irq_n, 0);
    ext_irq = 1'b0;
    cyc(2);
    check(irq_n == 1'b1, "R5 irq released", irq_n, 1);

    // R3 disabled: pin edge with flag set must not change anything
    exp_flag = 1'b0;
    prep_round();
    pulse(3);
    cyc(REC + 20);
    judge(1'b1, 1'b1, "pre-disable");
    ctl_write(3'b110);
    prep_round();
    pulse(5);
    cyc(REC + 20);
    judge(1'b0, 1'b1, "disabled flag kept");

    // R8 second edge during a running fill is ignored
    ctl_write(3'b001);
    prep_round();
    pulse(4);
    cyc(30);
    check(wr_en == 1'b1, "R8 fill running", wr_en, 1);
    pulse(4);
    cyc(REC + 40);
    check(wr_count == N, "R8 single fill", wr_count, N);
    judge(1'b1, 1'b0, "retrigger");

    // R9 clear write lands on the completing edge: set wins
    ctl_write(3'b011);
    prep_round();
    pulse(4);
    while (!(wr_en && int'(wr_addr) == N - 1)) @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = 3'b011;
    @(negedge clk);
    ctl_we = 1'b0;
    check(ctl_rdata[2] == 1'b1, "R9 set beats clear", ctl_rdata[2], 1);
    cyc(1);
    check(irq_n == 1'b0, "R9 irq after collision", irq_n, 0);
    exp_flag = 1'b1;
    cyc(REC);
    ctl_write(3'b011);
    cyc(2);
    check(irq_n == 1'b1 && ctl_rdata[2] == 1'b0, "R9 later clear", irq_n, 1);

    // random rounds
    for (int r = 0; r < 16; r++) begin
      bit en = 1'($urandom_range(0, 1));
      bit ie = 1'($urandom_range(0, 1));
      bit fb = 1'($urandom_range(0, 1));
      ext_irq = ($urandom_range(0, 3) == 0);
      ctl_write({fb, ie, en});
      check(ctl_rdata[2] == exp_flag, "R6 random flag write", ctl_rdata[2], exp_flag);
      prep_round();
      pulse($urandom_range(3, 12));
      cyc(REC + 20);
      judge(en, ie, "random");
    end
    ext_irq = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule